// File: doc/BRIEF.md
# Power-Management Sleep Control Register

This block holds the 16-bit control word that system software uses to select a sleep state and to steer system-control interrupts. It sits on a little-endian register bus that carries byte and halfword accesses. The low byte of the register is at the base address and the high byte is one address above it. Software may read either byte. A byte write to the high half merges with the low byte already stored, so a sleep request can be issued with one byte write.

Bit 13 is the sleep trigger. It is never stored. When a write sets it, bits 12:10 of the written value choose the sleep type:
- Type 0 raises a soft-off request.
- Type 1 raises a suspend request.
- The type equal to the runtime hibernate code raises a hibernate notification, and a soft-off request follows it.
- Any other type is ignored.

A management path can set or clear the interrupt-enable bit (bit 0) by command. A strap selects interrupt-only operation. In that mode bit 0 comes out of reset set, and the management commands have no effect.

Top module: `pm_sleep_ctrl`

## Requirements
- R1: Reset clears the register to 16'h0000 when `acpi_only` is low and sets it to 16'h0001 when `acpi_only` is high. All three request outputs are low after reset.
- R2: Reads of the register are combinational.
  - A read at address 4 returns the whole register.
  - A read at address 5 returns {8'h00, register[15:8]}.
  - Any other address returns zero with `bus_hit` low, and a write there changes nothing.
- R3: A halfword write (`bus_size`=1) at address 4 stores `bus_wdata` with bit 13 cleared. A byte write (`bus_size`=0) at address 4 stores {8'h00, `bus_wdata[7:0]`} with bit 13 cleared.
- R4: A write at address 5 uses only `bus_wdata[7:0]`. It forms the value {`bus_wdata[7:0]`, stored[7:0]}, and that value is both stored (bit 13 cleared) and decoded.
- R5: Bit 13 always reads as 0.
- R6: A write whose formed value has bit 13 set and type (bits 12:10) 0 raises `req_off` for exactly one cycle, in the cycle after the write.
- R7: Such a write with type 1 raises `req_suspend` for one cycle, in the cycle after the write.
- R8: Such a write with a type from 2 to 7 that equals `hib_code` raises `req_hib` for one cycle after the write, then `req_off` for one cycle after that. A `hib_code` of 0 or 1 never causes a hibernate pulse. Any other type causes no pulse.
- R9: When `acpi_only` is low:
  - `smi_sci_en` sets bit 0.
  - `smi_sci_dis` clears bit 0 only when `smi_sci_en` is low.
  - A command overrides bit 0 of a same-cycle bus write.
- R10: When `acpi_only` is high, `smi_sci_en` and `smi_sci_dis` leave the register unchanged. Bus writes still update it.
- R11: Every request pulse returns low in the cycle after it was raised, unless a new trigger arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acpi_only | input | 1 | Strap: interrupt-only mode |
| hib_code | input | 3 | Sleep type that means hibernate |
| bus_addr | input | 4 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_size | input | 1 | 1 = halfword, 0 = byte |
| bus_wdata | input | 16 | Write data, byte lane in bits 7:0 |
| bus_rdata | output | 16 | Read data |
| bus_hit | output | 1 | Address decodes to this register |
| smi_sci_en | input | 1 | Management command: set interrupt enable |
| smi_sci_dis | input | 1 | Management command: clear interrupt enable |
| req_off | output | 1 | Soft-off request pulse |
| req_suspend | output | 1 | Suspend request pulse |
| req_hib | output | 1 | Hibernate notification pulse |

## Verification
The bench targets the corner cases below.

- **High-byte write.** The bench issues a byte write to the high half whose bit 5 carries the trigger. A design that decoded the raw byte instead of the merged value would miss the suspend request or would corrupt the low byte.
- **Unmatched sleep types.** It issues types that match neither the fixed codes nor `hib_code`, and it sets `hib_code` to 1. A design that checked hibernate before suspend would fire the wrong pulse.
- **Hibernate sequence.** It checks that `req_off` follows `req_hib` by exactly one cycle.
- **Command priority.** It drives enable and disable together, and a command alongside a bus write. A design with the wrong priority would leave bit 0 in the wrong state.
- **Interrupt-only mode.** It checks the reset value and that commands are locked out, while bus writes still clear bit 0.

// File: rtl/pm_sleep_ctrl.sv
module pm_sleep_ctrl #(
  parameter int ADDR_W  = 4,
  parameter int BASE    = 4,
  parameter int SCI_BIT = 0,
  parameter int SLP_BIT = 13,
  parameter int TYP_LSB = 10,
  parameter int TYP_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acpi_only,
  input  logic [TYP_W-1:0]  hib_code,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_size,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_hit,
  input  logic              smi_sci_en,
  input  logic              smi_sci_dis,
  output logic              req_off,
  output logic              req_suspend,
  output logic              req_hib
);
  localparam logic [ADDR_W-1:0] ADR_LO = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] ADR_HI = ADDR_W'(BASE + 1);
  localparam logic [15:0] SLP_MASK = 16'(1) << SLP_BIT;

  logic [15:0]      ctrl, wr_val, nxt, rst_val;
  logic [TYP_W-1:0] slp_type;
  logic             hit_lo, hit_hi, wr_go, fire, is_off, is_sus, is_hib;

  assign hit_lo   = (bus_addr == ADR_LO);
  assign hit_hi   = (bus_addr == ADR_HI);
  assign bus_hit  = hit_lo | hit_hi;
  assign bus_rdata = hit_lo ? ctrl : (hit_hi ? {8'h00, ctrl[15:8]} : 16'h0000);

  assign wr_val   = hit_hi   ? {bus_wdata[7:0], ctrl[7:0]} :
                    bus_size ? bus_wdata : {8'h00, bus_wdata[7:0]};
  assign wr_go    = bus_wr & bus_hit;
  assign fire     = wr_go & wr_val[SLP_BIT];
  assign slp_type = wr_val[TYP_LSB +: TYP_W];
  assign is_off   = (slp_type == '0);
  assign is_sus   = (slp_type == TYP_W'(1));
  assign is_hib   = !is_off && !is_sus && (slp_type == hib_code);

  always_comb begin
    rst_val = 16'h0000;
    rst_val[SCI_BIT] = acpi_only;
  end

  always_comb begin
    nxt = ctrl;
    if (wr_go) nxt = wr_val & ~SLP_MASK;
    if (!acpi_only) begin
      if (smi_sci_en)       nxt[SCI_BIT] = 1'b1;
      else if (smi_sci_dis) nxt[SCI_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl        <= rst_val;
      req_off     <= 1'b0;
      req_suspend <= 1'b0;
      req_hib     <= 1'b0;
    end else begin
      ctrl        <= nxt;
      req_suspend <= fire & is_sus;
      req_hib     <= fire & is_hib;
      req_off     <= (fire & is_off) | req_hib;
    end
  end

  assert_sleep_bit_never_stored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[SLP_BIT] == 1'b0);

  assert_hib_then_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_hib |=> req_off);

  assert_suspend_trigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && slp_type == TYP_W'(1)) |=> (req_suspend && !req_hib));

  assert_off_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_off |-> ($past(fire && slp_type == '0) || $past(req_hib)));

  assert_cmd_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acpi_only && !wr_go) |=> $stable(ctrl));

  assert_enable_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!acpi_only && smi_sci_en) |=> ctrl[SCI_BIT]);

  assert_miss_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_hit && (acpi_only || !(smi_sci_en || smi_sci_dis))) |=> $stable(ctrl));
endmodule

// File: tb/tb_pm_sleep_ctrl.sv
`timescale 1ns/1ps
module tb_pm_sleep_ctrl;
  logic clk = 0, rst_n = 0, acpi_only = 0;
  logic [2:0] hib_code = 3'd5;
  logic [3:0] bus_addr = 4'd4;
  logic bus_wr = 0, bus_size = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic bus_hit, smi_sci_en = 0, smi_sci_dis = 0;
  logic req_off, req_suspend, req_hib;
  int errs = 0, checks = 0;

  always #2 clk = ~clk;

  pm_sleep_ctrl dut (.clk, .rst_n, .acpi_only, .hib_code, .bus_addr, .bus_wr, .bus_size,
    .bus_wdata, .bus_rdata, .bus_hit, .smi_sci_en, .smi_sci_dis, .req_off, .req_suspend, .req_hib);

  typedef struct packed {
    logic [1:0]  off;
    logic        size;
    logic [15:0] wd;
    logic [15:0] exp_reg;
    logic [2:0]  exp_p;   // {hib, suspend, off} in cycle after the write
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{2'd0, 1'b1, 16'h0201, 16'h0201, 3'b000},
    '{2'd1, 1'b0, 16'h00A5, 16'h8501, 3'b010},
    '{2'd0, 1'b0, 16'h12FF, 16'h00FF, 3'b000},
    '{2'd0, 1'b1, 16'h2000, 16'h0000, 3'b001},
    '{2'd0, 1'b1, 16'h3401, 16'h1401, 3'b100},
    '{2'd0, 1'b1, 16'h3001, 16'h1001, 3'b000},
    '{2'd2, 1'b1, 16'hFFFF, 16'h1001, 3'b000},
    '{2'd0, 1'b1, 16'h1C00, 16'h1C00, 3'b000},
    '{2'd0, 1'b1, 16'h2403, 16'h0403, 3'b010},
    '{2'd1, 1'b0, 16'h003C, 16'h1C03, 3'b000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [1:0] off, input logic sz,
                       input logic [15:0] wd, input logic en, input logic dis);
    @(negedge clk);
    bus_addr = 4'(4 + off); bus_size = sz; bus_wdata = wd; bus_wr = wr;
    smi_sci_en = en; smi_sci_dis = dis;
    @(negedge clk);
    bus_wr = 0; smi_sci_en = 0; smi_sci_dis = 0; bus_addr = 4'd4; bus_size = 1;
  endtask

  task automatic read_at(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a; #0.5; d = bus_rdata; bus_addr = 4'd4; #0.5;
  endtask

  task automatic do_reset;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(4 * 200000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    do_reset();
    read_at(4'd4, d); check("R1 reset value", d, 16'h0000);
    check("R1 pulses after reset", {req_hib, req_suspend, req_off}, 3'b000);
    read_at(4'd5, d); check("R2 high byte after reset", d, 16'h0000);

    foreach (VEC[i]) begin
      drive(1'b1, VEC[i].off, VEC[i].size, VEC[i].wd, 1'b0, 1'b0);
      check($sformatf("R6/R7/R8 vector %0d pulses", i), {req_hib, req_suspend, req_off}, VEC[i].exp_p);
      read_at(4'd4, d);
      check($sformatf("R3/R4/R5 vector %0d stored", i), d, VEC[i].exp_reg);
      @(negedge clk);
      check($sformatf("R8/R11 vector %0d next cycle", i), {req_hib, req_suspend, req_off},
            {2'b00, VEC[i].exp_p[2]});
    end

    read_at(4'd5, d); check("R2 read high byte", d, 16'h001C);
    bus_addr = 4'd6; #0.5; check("R2 miss rdata", bus_rdata, 16'h0000);
    check("R2 miss hit flag", bus_hit, 1'b0); bus_addr = 4'd4; #0.5;

    drive(1'b0, 2'd0, 1'b1, 16'h0, 1'b0, 1'b1);
    read_at(4'd4, d); check("R9 disable clears bit0", d, 16'h1C02);
    drive(1'b0, 2'd0, 1'b1, 16'h0, 1'b1, 1'b1);
    read_at(4'd4, d); check("R9 enable beats disable", d, 16'h1C03);
    drive(1'b1, 2'd0, 1'b1, 16'h0001, 1'b0, 1'b1);
    read_at(4'd4, d); check("R9 disable overrides bus write", d, 16'h0000);
    drive(1'b1, 2'd0, 1'b1, 16'h0000, 1'b1, 1'b0);
    read_at(4'd4, d); check("R9 enable overrides bus write", d, 16'h0001);

    hib_code = 3'd1;
    drive(1'b1, 2'd0, 1'b1, 16'h2400, 1'b0, 1'b0);
    check("R8 hib_code 1 gives suspend only", {req_hib, req_suspend, req_off}, 3'b010);
    @(negedge clk);
    check("R11 suspend pulse ends", {req_hib, req_suspend, req_off}, 3'b000);

    hib_code = 3'd7;
    drive(1'b1, 2'd0, 1'b1, 16'h3C00, 1'b0, 1'b0);
    check("R8 hib type 7", {req_hib, req_suspend, req_off}, 3'b100);
    @(negedge clk);
    check("R8 off follows hib", {req_hib, req_suspend, req_off}, 3'b001);
    @(negedge clk);
    check("R11 off pulse ends", {req_hib, req_suspend, req_off}, 3'b000);
    hib_code = 3'd5;

    acpi_only = 1;
    do_reset();
    read_at(4'd4, d); check("R1 reset value in interrupt-only mode", d, 16'h0001);
    drive(1'b0, 2'd0, 1'b1, 16'h0, 1'b0, 1'b1);
    read_at(4'd4, d); check("R10 disable ignored", d, 16'h0001);
    drive(1'b1, 2'd0, 1'b1, 16'h0000, 1'b0, 1'b0);
    read_at(4'd4, d); check("R10 bus write still clears", d, 16'h0000);
    drive(1'b0, 2'd0, 1'b1, 16'h0, 1'b1, 1'b0);
    read_at(4'd4, d); check("R10 enable ignored", d, 16'h0000);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule